// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves words between a simple memory port and a pair of data streams, one toward a device and one from it. The work list is a chain of 16-byte descriptors in memory. Each descriptor names a buffer and its byte length, carries control flags, and says where the next descriptor lies. Software loads a descriptor base pointer, turns the engine on in the mode register, and then writes the kick register. The engine reads a descriptor and checks that it owns it. It then streams the buffer, hands the descriptor back by clearing its ownership flag in memory, and moves on until it finishes a descriptor flagged as the last one.

Configuration arrives over a write-only register port. The engine reports through sticky status bits and a one-cycle completion pulse. Two self-clearing resets are provided. The engine reset aborts the chain and keeps the configuration. The soft reset also wipes the configuration.

Top module: `desc_chain_dma`

## Requirements
- R1: After `rst_n` is released, `busy`, `xfer_done`, `stat_unavail`, `stat_buserr`, `dma_rst_active`, `soft_rst_active`, `mem_req`, `tx_valid`, `rx_ready` and `mem_fixed_burst` are all 0.
- R2: A descriptor is four words at consecutive word addresses: flags, byte length, buffer address, next pointer. In the device-bound direction (CTRL bit1 = 0) the buffer words are read in ascending address order and presented on `tx_data`. A byte length that is not a multiple of 4 is rounded up to whole words.
- R3: After its buffer is done, the engine writes the descriptor's flag word back to memory with bit31 (owned) cleared and every other bit unchanged. This happens before any later descriptor is fetched. The other three words are left untouched.
- R4: If flag bit4 (chained) is set, the next descriptor is fetched from the next-pointer word with its low 4 bits forced to 0. Otherwise it is fetched from the current descriptor address plus 16.
- R5: Finishing a descriptor with flag bit2 (last) ends the chain and returns the pointer to the base register. `xfer_done` pulses for exactly one cycle unless flag bit1 (no interrupt) is set.
- R6: A flag word with bit31 clear stops the engine before any data moves and sets `stat_unavail`. The next kick resumes from that same descriptor.
- R7: With CTRL bit1 = 1, words taken from the rx stream are written to the buffer in ascending address order.
- R8: An error response on any memory access aborts the chain without writing back the flag word and sets `stat_buserr`. Writing a 1 to STATUS bit0 clears `stat_unavail`, and writing a 1 to bit1 clears `stat_buserr`.
- R9: A descriptor whose buffer address plus byte length exceeds 2^32 is treated as a bus error, and none of its buffer is accessed.
- R10: A kick does nothing while MODE bit7 (enable) is 0.
- R11: Writing 1 to CTRL bit0 starts the engine reset. The reset aborts any chain, clears both status bits, keeps the base pointer and mode, and ends by itself after RST_CYCLES cycles, which `dma_rst_active` shows.
- R12: Writing 1 to MODE bit0 starts the soft reset. It clears base, mode, direction and status, and ends by itself after RST_CYCLES cycles, which `soft_rst_active` shows.
- R13: A descriptor with byte length 0 moves no data but is still written back and followed.
- R14: `mem_fixed_burst` follows MODE bit1.

Register offsets on `cfg_addr`: 0 BASE, 1 MODE, 2 KICK (any data), 3 CTRL, 4 STATUS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_fixed_burst | output | 1 | Fixed-burst hint from the mode register |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Device-bound word valid |
| tx_ready | input | 1 | Device accepts word |
| tx_data | output | 32 | Device-bound word |
| rx_valid | input | 1 | Word from device valid |
| rx_ready | output | 1 | Engine accepts word |
| rx_data | input | 32 | Word from device |
| busy | output | 1 | Engine is working through a chain |
| xfer_done | output | 1 | One-cycle pulse at chain completion |
| stat_unavail | output | 1 | Sticky: stopped on a descriptor it did not own |
| stat_buserr | output | 1 | Sticky: chain aborted by a bus error |
| dma_rst_active | output | 1 | Engine reset in progress |
| soft_rst_active | output | 1 | Soft reset in progress |

## Verification
The embedded properties watch every cycle for the handshake rules: a pending memory request and an offered tx word keep their values until accepted, at most one of the three data-side strobes is active, the completion pulse lasts one cycle, and the engine is idle whenever a reset is running or an unowned descriptor has just stopped it. Only the directed scenarios can show the data path as a whole. They show the order of words, the contents of the written-back flag words, the way next-pointer and adjacency addresses are followed, resumption after a stall on an unowned descriptor, the error aborts, and what each reset keeps or discards.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   // register offsets on the configuration port
   localparam logic [2:0] REG_BASE = 3'd0;
   localparam logic [2:0] REG_MODE = 3'd1;
   localparam logic [2:0] REG_KICK = 3'd2;
   localparam logic [2:0] REG_CTRL = 3'd3;
   localparam logic [2:0] REG_STAT = 3'd4;

   // descriptor flag word bit positions
   localparam int FLG_OWN   = 31;
   localparam int FLG_CHAIN = 4;
   localparam int FLG_LAST  = 2;
   localparam int FLG_NOIRQ = 1;

   // mode register
   localparam int MD_SWRST = 0;
   localparam int MD_FIXB  = 1;
   localparam int MD_EN    = 7;

   // control register
   localparam int CT_DMARST = 0;
   localparam int CT_TOMEM  = 1;

   // status register (write 1 to clear)
   localparam int ST_UNAV = 0;
   localparam int ST_BERR = 1;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FETCH,
      S_CHECK,
      S_XRD,
      S_XPUSH,
      S_XPOP,
      S_XWR,
      S_WBACK,
      S_NEXT
   } seq_state_t;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
   import dma_chain_pkg::*;
#(
   parameter int RST_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   input  logic        set_unav,
   input  logic        set_berr,
   output logic [31:0] base_addr,
   output logic        eng_en,
   output logic        fixed_burst,
   output logic        to_mem,
   output logic        kick,
   output logic        ptr_load,
   output logic [31:0] ptr_load_val,
   output logic        hold,
   output logic        unav,
   output logic        berr,
   output logic        drst_busy,
   output logic        srst_busy
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYCLES);

   generate
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] drst_cnt, srst_cnt;
   logic          wr_ok, srst_req, drst_req;
   logic          unused_bits;

   assign drst_busy = (drst_cnt != '0);
   assign srst_busy = (srst_cnt != '0);
   assign wr_ok     = cfg_we && !drst_busy && !srst_busy;
   assign srst_req  = wr_ok && (cfg_addr == REG_MODE) && cfg_wdata[MD_SWRST];
   assign drst_req  = wr_ok && (cfg_addr == REG_CTRL) && cfg_wdata[CT_DMARST];

   // the write that starts a reset already holds the sequencer
   assign hold         = drst_busy || srst_busy || srst_req || drst_req;
   assign kick         = wr_ok && (cfg_addr == REG_KICK);
   assign ptr_load     = wr_ok && (cfg_addr == REG_BASE);
   assign ptr_load_val = {cfg_wdata[31:4], 4'b0000};
   assign unused_bits  = ^cfg_wdata[6:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drst_cnt    <= '0;
         srst_cnt    <= '0;
         base_addr   <= '0;
         eng_en      <= 1'b0;
         fixed_burst <= 1'b0;
         to_mem      <= 1'b0;
         unav        <= 1'b0;
         berr        <= 1'b0;
      end else begin
         if (drst_busy) drst_cnt <= drst_cnt - 1'b1;
         if (srst_busy) srst_cnt <= srst_cnt - 1'b1;
         if (wr_ok) begin
            case (cfg_addr)
               REG_BASE: base_addr <= ptr_load_val;
               REG_MODE: begin
                  if (cfg_wdata[MD_SWRST]) begin
                     srst_cnt    <= RST_LOAD;
                     base_addr   <= '0;
                     eng_en      <= 1'b0;
                     fixed_burst <= 1'b0;
                     to_mem      <= 1'b0;
                     unav        <= 1'b0;
                     berr        <= 1'b0;
                  end else begin
                     eng_en      <= cfg_wdata[MD_EN];
                     fixed_burst <= cfg_wdata[MD_FIXB];
                  end
               end
               REG_CTRL: begin
                  to_mem <= cfg_wdata[CT_TOMEM];
                  if (cfg_wdata[CT_DMARST]) begin
                     drst_cnt <= RST_LOAD;
                     unav     <= 1'b0;
                     berr     <= 1'b0;
                  end
               end
               REG_STAT: begin
                  if (cfg_wdata[ST_UNAV]) unav <= 1'b0;
                  if (cfg_wdata[ST_BERR]) berr <= 1'b0;
               end
               default: ;
            endcase
         end
         // a status event in the same cycle as a clear wins
         if (set_unav) unav <= 1'b1;
         if (set_berr) berr <= 1'b1;
      end
   end

   a_r11_reset_counter_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (drst_cnt <= RST_LOAD) && (srst_cnt <= RST_LOAD));
endmodule

// File: rtl/dma_chain_len.sv
module dma_chain_len #(
   parameter bit ROUND_UP = 1'b1
) (
   input  logic [31:0] byte_len,
   input  logic [31:0] buf_addr,
   output logic [30:0] word_cnt,
   output logic        span_ok
);
   logic [32:0] span_end;

   generate
      if (ROUND_UP) begin : g_round_up
         logic [32:0] padded;
         logic [32:0] shifted;
         logic        unused_top;
         assign padded     = {1'b0, byte_len} + 33'd3;
         assign shifted    = padded >> 2;
         assign word_cnt   = shifted[30:0];
         assign unused_top = ^{shifted[32:31], byte_len[1:0]};
      end else begin : g_truncate
         logic unused_low;
         assign word_cnt   = {1'b0, byte_len[31:2]};
         assign unused_low = ^byte_len[1:0];
      end
   endgenerate

   // the whole buffer must end inside the 32-bit space
   assign span_end = {1'b0, buf_addr} + {1'b0, byte_len};
   assign span_ok  = (span_end <= 33'h1_0000_0000);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_chain_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hold,
   input  logic        kick,
   input  logic        eng_en,
   input  logic        to_mem,
   input  logic [31:0] base_addr,
   input  logic        ptr_load,
   input  logic [31:0] ptr_load_val,
   input  logic [30:0] word_cnt,
   input  logic        span_ok,
   output logic [31:0] d_len,
   output logic [31:0] d_buf,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic        mem_err,
   input  logic [31:0] mem_rdata,
   output logic        tx_valid,
   input  logic        tx_ready,
   output logic [31:0] tx_data,
   input  logic        rx_valid,
   output logic        rx_ready,
   input  logic [31:0] rx_data,
   output logic        set_unav,
   output logic        set_berr,
   output logic        busy,
   output logic        xfer_done
);
   seq_state_t  st;
   logic [31:0] cur_ptr, d_flags, waddr, hold_q;
   logic [27:0] d_nxt;
   logic [1:0]  widx;
   logic [30:0] wleft;
   logic        done_q;

   assign busy      = (st != S_IDLE);
   assign xfer_done = done_q;
   assign tx_data   = hold_q;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      tx_valid  = 1'b0;
      rx_ready  = 1'b0;
      set_unav  = 1'b0;
      set_berr  = 1'b0;
      case (st)
         S_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = {cur_ptr[31:4], widx, 2'b00};
            if (mem_ack && !hold) begin
               if (mem_err) set_berr = 1'b1;
               else if (widx == 2'd0 && !mem_rdata[FLG_OWN]) set_unav = 1'b1;
            end
         end
         S_CHECK: if (!hold && !span_ok) set_berr = 1'b1;
         S_XRD: begin
            mem_req  = 1'b1;
            mem_addr = waddr;
            if (mem_ack && mem_err && !hold) set_berr = 1'b1;
         end
         S_XPUSH: tx_valid = 1'b1;
         S_XPOP:  rx_ready = 1'b1;
         S_XWR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = waddr;
            mem_wdata = hold_q;
            if (mem_ack && mem_err && !hold) set_berr = 1'b1;
         end
         S_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_ptr;
            mem_wdata = {1'b0, d_flags[30:0]};
            if (mem_ack && mem_err && !hold) set_berr = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cur_ptr <= '0;
         d_flags <= '0;
         d_len   <= '0;
         d_buf   <= '0;
         d_nxt   <= '0;
         widx    <= '0;
         wleft   <= '0;
         waddr   <= '0;
         hold_q  <= '0;
         done_q  <= 1'b0;
      end else if (hold) begin
         st      <= S_IDLE;
         cur_ptr <= base_addr;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            S_IDLE: begin
               if (ptr_load) cur_ptr <= ptr_load_val;
               if (kick && eng_en) begin
                  st   <= S_FETCH;
                  widx <= 2'd0;
               end
            end
            S_FETCH: if (mem_ack) begin
               if (mem_err) begin
                  st      <= S_IDLE;
                  cur_ptr <= base_addr;
               end else begin
                  case (widx)
                     2'd0: d_flags <= mem_rdata;
                     2'd1: d_len   <= mem_rdata;
                     2'd2: d_buf   <= mem_rdata;
                     default: d_nxt <= mem_rdata[31:4];
                  endcase
                  widx <= widx + 2'd1;
                  if (widx == 2'd0 && !mem_rdata[FLG_OWN]) st <= S_IDLE;
                  else if (widx == 2'd3) st <= S_CHECK;
               end
            end
            S_CHECK: begin
               if (!span_ok) begin
                  st      <= S_IDLE;
                  cur_ptr <= base_addr;
               end else if (word_cnt == '0) begin
                  st <= S_WBACK;
               end else begin
                  wleft <= word_cnt;
                  waddr <= d_buf;
                  st    <= to_mem ? S_XPOP : S_XRD;
               end
            end
            S_XRD: if (mem_ack) begin
               if (mem_err) begin
                  st      <= S_IDLE;
                  cur_ptr <= base_addr;
               end else begin
                  hold_q <= mem_rdata;
                  st     <= S_XPUSH;
               end
            end
            S_XPUSH: if (tx_ready) begin
               wleft <= wleft - 1'b1;
               waddr <= waddr + 32'd4;
               st    <= (wleft == 31'd1) ? S_WBACK : S_XRD;
            end
            S_XPOP: if (rx_valid) begin
               hold_q <= rx_data;
               st     <= S_XWR;
            end
            S_XWR: if (mem_ack) begin
               if (mem_err) begin
                  st      <= S_IDLE;
                  cur_ptr <= base_addr;
               end else begin
                  wleft <= wleft - 1'b1;
                  waddr <= waddr + 32'd4;
                  st    <= (wleft == 31'd1) ? S_WBACK : S_XPOP;
               end
            end
            S_WBACK: if (mem_ack) begin
               if (mem_err) begin
                  st      <= S_IDLE;
                  cur_ptr <= base_addr;
               end else begin
                  st <= S_NEXT;
               end
            end
            S_NEXT: begin
               if (d_flags[FLG_LAST]) begin
                  done_q  <= !d_flags[FLG_NOIRQ];
                  cur_ptr <= base_addr;
                  st      <= S_IDLE;
               end else begin
                  cur_ptr <= d_flags[FLG_CHAIN] ? {d_nxt, 4'b0000} : cur_ptr + 32'd16;
                  widx    <= 2'd0;
                  st      <= S_FETCH;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R2: a pending memory request keeps its address and kind until acknowledged
   a_r2_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !hold) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                          && $stable(mem_wdata)));

   // R2: an offered device word stays until it is taken
   a_r2_tx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !hold) |=> (tx_valid && $stable(tx_data)));

   // R7: memory, tx and rx sides are never worked in the same cycle
   a_r7_single_side: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, tx_valid, rx_ready}));

   // R5: the completion pulse lasts one cycle
   a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
   import dma_chain_pkg::*;
#(
   parameter int RST_CYCLES = 4,
   parameter bit ROUND_UP   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   output logic        mem_fixed_burst,
   input  logic        mem_ack,
   input  logic        mem_err,
   input  logic [31:0] mem_rdata,
   output logic        tx_valid,
   input  logic        tx_ready,
   output logic [31:0] tx_data,
   input  logic        rx_valid,
   output logic        rx_ready,
   input  logic [31:0] rx_data,
   output logic        busy,
   output logic        xfer_done,
   output logic        stat_unavail,
   output logic        stat_buserr,
   output logic        dma_rst_active,
   output logic        soft_rst_active
);
   logic [31:0] base_addr, ptr_load_val, d_len, d_buf;
   logic        eng_en, to_mem, kick, ptr_load, hold;
   logic        set_unav, set_berr, span_ok;
   logic [30:0] word_cnt;

   dma_chain_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .set_unav     (set_unav),
      .set_berr     (set_berr),
      .base_addr    (base_addr),
      .eng_en       (eng_en),
      .fixed_burst  (mem_fixed_burst),
      .to_mem       (to_mem),
      .kick         (kick),
      .ptr_load     (ptr_load),
      .ptr_load_val (ptr_load_val),
      .hold         (hold),
      .unav         (stat_unavail),
      .berr         (stat_buserr),
      .drst_busy    (dma_rst_active),
      .srst_busy    (soft_rst_active)
   );

   dma_chain_len #(.ROUND_UP(ROUND_UP)) u_len (
      .byte_len (d_len),
      .buf_addr (d_buf),
      .word_cnt (word_cnt),
      .span_ok  (span_ok)
   );

   dma_chain_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .hold         (hold),
      .kick         (kick),
      .eng_en       (eng_en),
      .to_mem       (to_mem),
      .base_addr    (base_addr),
      .ptr_load     (ptr_load),
      .ptr_load_val (ptr_load_val),
      .word_cnt     (word_cnt),
      .span_ok      (span_ok),
      .d_len        (d_len),
      .d_buf        (d_buf),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_ack      (mem_ack),
      .mem_err      (mem_err),
      .mem_rdata    (mem_rdata),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .tx_data      (tx_data),
      .rx_valid     (rx_valid),
      .rx_ready     (rx_ready),
      .rx_data      (rx_data),
      .set_unav     (set_unav),
      .set_berr     (set_berr),
      .busy         (busy),
      .xfer_done    (xfer_done)
   );

   // R11 / R12: the sequencer is idle for the whole of either reset
   a_r11_reset_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rst_active || soft_rst_active) |-> !busy);

   // R6: the engine has stopped when an unowned descriptor is reported
   a_r6_unavail_stops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_unavail) |-> !busy);
endmodule

// File: tb/desc_chain_dma_test.sv
module desc_chain_dma_test;
   localparam int RSTC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_req, mem_we, mem_fixed_burst;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        tx_valid, rx_ready;
   logic        tx_rdy = 1'b1;
   logic [31:0] tx_data;
   logic [31:0] rx_seq = 32'hB000_0000;
   logic        busy, xfer_done, stat_unavail, stat_buserr, dma_rst_active, soft_rst_active;
   logic        stall_en = 1'b0;

   logic [31:0] mem [0:1023];
   logic [31:0] tx_log [0:63];
   int tx_cnt = 0, done_cnt = 0, nacc = 0;
   int nchk = 0, nfail = 0;

   always #2.5 clk = ~clk;

   desc_chain_dma #(.RST_CYCLES(RSTC)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_fixed_burst(mem_fixed_burst), .mem_ack(mem_ack), .mem_err(mem_err),
      .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_rdy), .tx_data(tx_data),
      .rx_valid(1'b1), .rx_ready(rx_ready), .rx_data(rx_seq),
      .busy(busy), .xfer_done(xfer_done), .stat_unavail(stat_unavail),
      .stat_buserr(stat_buserr), .dma_rst_active(dma_rst_active),
      .soft_rst_active(soft_rst_active)
   );

   // memory model: one-cycle acknowledge, error above 4 KiB
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         nacc    <= nacc + 1;
         mem_err <= (mem_addr[31:12] != 0);
         if (mem_addr[31:12] == 0) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else mem_rdata <= mem[mem_addr[11:2]];
         end
      end else mem_ack <= 1'b0;
   end

   always @(posedge clk) begin
      tx_rdy <= stall_en ? ~tx_rdy : 1'b1;
      if (rst_n && tx_valid && tx_rdy) begin
         tx_log[tx_cnt[5:0]] <= tx_data;
         tx_cnt <= tx_cnt + 1;
      end
      if (rx_ready) rx_seq <= rx_seq + 1;
      if (xfer_done) done_cnt <= done_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
   endtask

   task automatic kick_run();
      cfg(3'd2, 32'h0);
      wait_idle();
      repeat (2) @(negedge clk);
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] f, input logic [31:0] l,
                           input logic [31:0] b, input logic [31:0] n);
      mem[a[11:2]]      = f;
      mem[a[11:2] + 1]  = l;
      mem[a[11:2] + 2]  = b;
      mem[a[11:2] + 3]  = n;
   endtask

   function automatic logic [31:0] pat(input logic [31:0] a);
      return 32'h5A00_0000 | {22'd0, a[11:2]};
   endfunction

   task automatic t_reset_state();
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 flags", {24'd0, xfer_done, stat_unavail, stat_buserr, dma_rst_active,
          soft_rst_active, mem_req, tx_valid, rx_ready}, 32'd0);
      chk("R1 burst", {31'd0, mem_fixed_burst}, 32'd0);
   endtask

   task automatic t_chain();
      int t0 = tx_cnt, d0 = done_cnt;
      put_desc(32'h100, 32'h8000_0018, 32'd8, 32'h400, 32'h200);
      put_desc(32'h200, 32'h8000_0000, 32'd12, 32'h500, 32'hDEAD_0000);
      put_desc(32'h210, 32'h8000_0004, 32'd4, 32'h600, 32'h0);
      cfg(3'd0, 32'h100);
      stall_en = 1'b1;
      kick_run();
      stall_en = 1'b0;
      chk("R2 word count", tx_cnt - t0, 6);
      chk("R2 word0", tx_log[t0],     pat(32'h400));
      chk("R2 word1", tx_log[t0 + 1], pat(32'h404));
      chk("R4 chained follow", tx_log[t0 + 2], pat(32'h500));
      chk("R2 word4", tx_log[t0 + 4], pat(32'h508));
      chk("R4 adjacent follow", tx_log[t0 + 5], pat(32'h600));
      chk("R3 flags A", mem[32'h100 >> 2], 32'h0000_0018);
      chk("R3 flags B", mem[32'h200 >> 2], 32'h0000_0000);
      chk("R3 flags C", mem[32'h210 >> 2], 32'h0000_0004);
      chk("R3 next untouched", mem[32'h20C >> 2], 32'hDEAD_0000);
      chk("R5 done once", done_cnt - d0, 1);
   endtask

   task automatic t_noirq();
      int t0 = tx_cnt, d0 = done_cnt;
      put_desc(32'h300, 32'h8000_0006, 32'd4, 32'h604, 32'h0);
      cfg(3'd0, 32'h300);
      kick_run();
      chk("R5 no-irq silent", done_cnt - d0, 0);
      chk("R5 no-irq data", tx_log[t0], pat(32'h604));
      chk("R3 no-irq flags", mem[32'h300 >> 2], 32'h0000_0006);
   endtask

   task automatic t_unavail();
      int t0 = tx_cnt, d0 = done_cnt, a0 = nacc;
      put_desc(32'h320, 32'h0000_0004, 32'd4, 32'h640, 32'h0);
      cfg(3'd0, 32'h320);
      kick_run();
      chk("R6 unavail set", {31'd0, stat_unavail}, 32'd1);
      chk("R6 no data", tx_cnt - t0, 0);
      chk("R6 one fetch", nacc - a0, 1);
      mem[32'h320 >> 2] = 32'h8000_0004;
      kick_run();
      chk("R6 resume data", tx_log[t0], pat(32'h640));
      chk("R6 resume done", done_cnt - d0, 1);
      cfg(3'd4, 32'h1);
      chk("R8 unavail cleared", {31'd0, stat_unavail}, 32'd0);
   endtask

   task automatic t_to_mem();
      logic [31:0] s0;
      s0 = rx_seq;
      put_desc(32'h340, 32'h8000_0010, 32'd8, 32'h700, 32'h360);
      put_desc(32'h360, 32'h8000_0004, 32'd4, 32'h710, 32'h0);
      cfg(3'd3, 32'h2);
      cfg(3'd0, 32'h340);
      kick_run();
      chk("R7 word0", mem[32'h700 >> 2], s0);
      chk("R7 word1", mem[32'h704 >> 2], s0 + 1);
      chk("R7 word2", mem[32'h710 >> 2], s0 + 2);
      cfg(3'd3, 32'h0);
   endtask

   task automatic t_bus_error();
      int t0 = tx_cnt, d0 = done_cnt;
      put_desc(32'h380, 32'h8000_0004, 32'd4, 32'h2000, 32'h0);
      cfg(3'd0, 32'h380);
      kick_run();
      chk("R8 buserr set", {31'd0, stat_buserr}, 32'd1);
      chk("R8 no writeback", mem[32'h380 >> 2], 32'h8000_0004);
      chk("R8 no done", done_cnt - d0, 0);
      chk("R8 no data", tx_cnt - t0, 0);
      cfg(3'd4, 32'h2);
      chk("R8 buserr cleared", {31'd0, stat_buserr}, 32'd0);
   endtask

   task automatic t_overflow();
      int t0 = tx_cnt, a0 = nacc;
      put_desc(32'h3A0, 32'h8000_0004, 32'd8, 32'hFFFF_FFFC, 32'h0);
      cfg(3'd0, 32'h3A0);
      kick_run();
      chk("R9 buserr", {31'd0, stat_buserr}, 32'd1);
      chk("R9 fetch only", nacc - a0, 4);
      chk("R9 no data", tx_cnt - t0, 0);
      cfg(3'd4, 32'h3);
   endtask

   task automatic t_disabled();
      int a0 = nacc;
      put_desc(32'h300, 32'h8000_0006, 32'd4, 32'h604, 32'h0);
      cfg(3'd0, 32'h300);
      cfg(3'd1, 32'h0);
      kick_run();
      chk("R10 disabled idle", {31'd0, busy}, 32'd0);
      chk("R10 no access", nacc - a0, 0);
      cfg(3'd1, 32'h80);
   endtask

   task automatic t_zero_round();
      int t0 = tx_cnt;
      put_desc(32'h3C0, 32'h8000_0010, 32'd0, 32'h600, 32'h3E0);
      put_desc(32'h3E0, 32'h8000_0004, 32'd6, 32'h400, 32'h0);
      cfg(3'd0, 32'h3C0);
      kick_run();
      chk("R13 zero-length written back", mem[32'h3C0 >> 2], 32'h0000_0010);
      chk("R2 round-up count", tx_cnt - t0, 2);
      chk("R2 round-up last", tx_log[t0 + 1], pat(32'h404));
   endtask

   task automatic t_fixed_burst();
      cfg(3'd1, 32'h82);
      chk("R14 burst on", {31'd0, mem_fixed_burst}, 32'd1);
      cfg(3'd1, 32'h80);
      chk("R14 burst off", {31'd0, mem_fixed_burst}, 32'd0);
   endtask

   task automatic t_dma_reset();
      int t0 = tx_cnt;
      put_desc(32'h300, 32'h8000_0006, 32'd4, 32'h604, 32'h0);
      cfg(3'd0, 32'h300);
      cfg(3'd3, 32'h1);
      chk("R11 active", {31'd0, dma_rst_active}, 32'd1);
      repeat (RSTC - 1) @(negedge clk);
      chk("R11 still active", {31'd0, dma_rst_active}, 32'd1);
      @(negedge clk);
      chk("R11 self-cleared", {31'd0, dma_rst_active}, 32'd0);
      kick_run();
      chk("R11 base and mode kept", tx_cnt - t0, 1);
   endtask

   task automatic t_soft_reset();
      int a0, t0;
      put_desc(32'h300, 32'h8000_0006, 32'd4, 32'h604, 32'h0);
      cfg(3'd1, 32'h83);
      cfg(3'd1, 32'h81);
      chk("R12 active", {31'd0, soft_rst_active}, 32'd1);
      chk("R12 burst cleared", {31'd0, mem_fixed_burst}, 32'd0);
      repeat (RSTC) @(negedge clk);
      chk("R12 self-cleared", {31'd0, soft_rst_active}, 32'd0);
      a0 = nacc;
      kick_run();
      chk("R12 enable cleared", nacc - a0, 0);
      cfg(3'd1, 32'h80);
      a0 = nacc; t0 = tx_cnt;
      kick_run();
      chk("R12 base cleared fetch", nacc - a0, 1);
      chk("R12 base cleared no data", tx_cnt - t0, 0);
      chk("R12 base cleared unavail", {31'd0, stat_unavail}, 32'd1);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      for (int i = 256; i < 448; i++) mem[i] = 32'h5A00_0000 | i;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      cfg(3'd1, 32'h80);
      t_chain();
      t_noirq();
      t_unavail();
      t_to_mem();
      t_bus_error();
      t_overflow();
      t_disabled();
      t_zero_round();
      t_fixed_burst();
      t_dma_reset();
      t_soft_reset();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule